// File: doc/BRIEF.md
# Sync-Gated Sinc Decimation Filter

The block turns a one-bit oversampled data stream into signed PCM words. Each accepted input bit counts as +1 (bit high) or -1 (bit low). The bits pass through a cascade of integrators that runs at the input rate, then through differentiators that run once per decimation period. The filter order is chosen at run time. The words it produces go into a 16-entry show-ahead FIFO, which a consumer drains with a single pop strobe. Status outputs are a fill-level data-ready flag and one-cycle pulses that report a dropped word and a clipped word.

In free-running mode the filter captures all the time, starting right after reset. In sync mode the input stream is ignored until a sync pulse arrives. A sync pulse restarts the filter from zero and can optionally empty the FIFO. Capture can also stop by itself once the FIFO reaches its threshold, which gives one burst of words per sync event. After every restart, the first outputs of the cascade depend on inputs from before the restart. These outputs are discarded by a count that depends on the filter order.

Top module: `sinc_capture_top`

## Requirements
- R1: After reset the FIFO is empty: fifo_count is 0, data_ready is low (threshold of 1 or more), and overflow and saturate are low.
- R2: cfg_order selects the cascade. Code 0 is first order, code 1 is second order, code 2 is third order, and code 3 is a fast variant that runs as a second-order cascade. Input bit 1 counts as +1 and bit 0 counts as -1. The k-th output (k from 1) equals the input history, with zeros before the restart, convolved with N boxcars of length R and taken at input sample kR-1.
- R3: The decimation ratio R is cfg_ratio_m1+1, covering 1 to 256. One output is formed for every R accepted samples. At R=256 with third order, a constant input gives exactly +16777216 or -16777216.
- R4: After reset and after each sync restart, the first outputs are discarded: none for code 0, one for code 1, and two for codes 2 and 3.
- R5: With cfg_wide high, each FIFO word is the full filter result, sign-extended to 32 bits.
- R6: With cfg_wide low, the result is shifted arithmetically right by cfg_shift and clamped to the range -32768..32767, then sign-extended. A clamped word pulses saturate for one cycle, two cycles after the decimation sample.
- R7: The FIFO holds 16 words in arrival order. rd_data shows the oldest word. A pop while the FIFO is not empty removes that word.
- R8: data_ready is high exactly while fifo_count is at least cfg_thresh.
- R9: A word that arrives while the FIFO holds 16 words and no pop is made is dropped, and overflow pulses for one cycle.
- R10: With sync_en high, input bits are ignored until a sync pulse, and a sync pulse restarts the filter from zero.
- R11: A sync pulse with sync_fifo_clr high empties the FIFO. With sync_fifo_clr low, the FIFO contents are kept ahead of the new words.
- R12: With sync_auto_stop high in sync mode, capture halts once data_ready is high, so a burst leaves exactly cfg_thresh words. With sync_auto_stop low, capture continues until the next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | A new modulator bit is present this cycle |
| bit_in | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| cfg_order | input | 2 | Filter order code |
| cfg_ratio_m1 | input | 8 | Decimation ratio minus one |
| cfg_wide | input | 1 | 1 = 32-bit words, 0 = shifted 16-bit words |
| cfg_shift | input | 4 | Right shift used in 16-bit mode |
| cfg_thresh | input | 5 | FIFO fill level that raises data_ready |
| sync_en | input | 1 | Capture is gated by sync pulses |
| sync_fifo_clr | input | 1 | A sync pulse empties the FIFO |
| sync_auto_stop | input | 1 | Capture halts when data_ready is reached |
| sync_pulse | input | 1 | Sync event, one cycle |
| pop | input | 1 | Remove the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word |
| fifo_count | output | 5 | Words held in the FIFO |
| data_ready | output | 1 | Fill level is at or above threshold |
| overflow | output | 1 | Pulse: a word was dropped |
| saturate | output | 1 | Pulse: a word was clamped |

## Verification
The assertions check the invariants that must hold on every cycle. The FIFO level never exceeds 16. A drop pulse follows only a full FIFO. A clamp pulse occurs only in 16-bit mode. A clearing sync empties the FIFO on the next cycle. A halted burst keeps its level until the next pop or sync. Other properties depend on arithmetic over whole sequences of stimulus, and only the bench scenarios can show them: the exact filter values for every order and for several ratios, the number of settling outputs that are discarded, full-scale and clamping boundaries, word ordering across a sync that keeps the FIFO, and the exact burst length.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        ORD_SINC1 = 2'd0,
        ORD_SINC2 = 2'd1,
        ORD_SINC3 = 2'd2,
        ORD_FAST2 = 2'd3
    } order_e;

    localparam int MAX_STAGES = 3;

    // Number of integrator/differentiator pairs in use
    function automatic int stage_count(order_e o);
        case (o)
            ORD_SINC1: return 1;
            ORD_SINC2: return 2;
            ORD_SINC3: return 3;
            default:   return 2;
        endcase
    endfunction

    // Outputs to throw away after a restart
    function automatic logic [1:0] settle_drop(order_e o);
        case (o)
            ORD_SINC1: return 2'd0;
            ORD_SINC2: return 2'd1;
            default:   return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/sinc_core.sv
module sinc_core
    import sdm_pkg::*;
#(
    parameter int OSR_BITS = 8,
    parameter int ACC_W    = MAX_STAGES * OSR_BITS + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    smp_en,
    input  logic                    smp_bit,
    input  order_e                  order,
    input  logic [OSR_BITS-1:0]     ratio_m1,
    output logic                    res_vld,
    output logic signed [ACC_W-1:0] res
);
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t [MAX_STAGES-1:0] integ;
        acc_t [MAX_STAGES-1:0] dly;
        logic [OSR_BITS-1:0]   dcnt;
        logic [1:0]            skip;
        logic                  vld;
        acc_t                  out;
    } core_st_t;

    core_st_t st_d, st_q;
    acc_t     carry, tap, comb_v, diff;
    int       nst;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        nst      = stage_count(order);
        carry    = smp_bit ? acc_t'(1) : acc_t'(-1);
        tap      = '0;
        comb_v   = '0;
        diff     = '0;
        if (restart) begin
            st_d      = '0;
            st_d.skip = settle_drop(order);
        end else if (smp_en) begin
            // integrators: input rate, chained through the new values
            for (int i = 0; i < MAX_STAGES; i++) begin
                st_d.integ[i] = st_q.integ[i] + carry;
                carry         = st_d.integ[i];
                if (i == nst - 1) tap = st_d.integ[i];
            end
            if (st_q.dcnt == ratio_m1) begin
                st_d.dcnt = '0;
                comb_v    = tap;
                // differentiators: decimated rate, unused stages bypassed
                for (int i = 0; i < MAX_STAGES; i++) begin
                    if (i < nst) begin
                        diff        = comb_v - st_q.dly[i];
                        st_d.dly[i] = comb_v;
                        comb_v      = diff;
                    end
                end
                if (st_q.skip != 2'd0) begin
                    st_d.skip = st_q.skip - 2'd1;
                end else begin
                    st_d.vld = 1'b1;
                    st_d.out = comb_v;
                end
            end else begin
                st_d.dcnt = st_q.dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld = st_q.vld;
    assign res     = st_q.out;

endmodule

// File: rtl/pcm_format.sv
module pcm_format #(
    parameter int IN_W  = 26,
    parameter int OUT_W = 32,
    parameter int SH_W  = 4
) (
    input  logic signed [IN_W-1:0] din,
    input  logic                   wide,
    input  logic [SH_W-1:0]        shift,
    output logic [OUT_W-1:0]       word,
    output logic                   clip
);
    localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(32767);
    localparam logic signed [IN_W-1:0] NEG_LIM = -IN_W'(32768);

    logic signed [IN_W-1:0] shd;

    always_comb begin
        shd  = din >>> shift;
        clip = 1'b0;
        if (wide) begin
            word = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
        end else if (shd > POS_LIM) begin
            word = {{(OUT_W-16){1'b0}}, 16'h7FFF};
            clip = 1'b1;
        end else if (shd < NEG_LIM) begin
            word = {{(OUT_W-16){1'b1}}, 16'h8000};
            clip = 1'b1;
        end else begin
            word = {{(OUT_W-16){shd[15]}}, shd[15:0]};
        end
    end

endmodule

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          dropped
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        dropped = push && !do_push && !clr;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

endmodule

// File: rtl/sinc_capture_top.sv
module sinc_capture_top
    import sdm_pkg::*;
#(
    parameter int OSR_BITS = 8,
    parameter int DEPTH    = 16,
    parameter int DATA_W   = 32,
    parameter int SH_W     = 4,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_valid,
    input  logic                bit_in,
    input  logic [1:0]          cfg_order,
    input  logic [OSR_BITS-1:0] cfg_ratio_m1,
    input  logic                cfg_wide,
    input  logic [SH_W-1:0]     cfg_shift,
    input  logic [CW-1:0]       cfg_thresh,
    input  logic                sync_en,
    input  logic                sync_fifo_clr,
    input  logic                sync_auto_stop,
    input  logic                sync_pulse,
    input  logic                pop,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CW-1:0]       fifo_count,
    output logic                data_ready,
    output logic                overflow,
    output logic                saturate
);
    localparam int ACC_W = MAX_STAGES * OSR_BITS + 2;

    typedef struct packed {
        logic started;
        logic cap;
        logic ovf;
        logic sat;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic                    sync_hit, restart, smp_en, hold, push, fifo_clr;
    logic                    res_vld, clip, dropped;
    logic signed [ACC_W-1:0] res;
    logic [DATA_W-1:0]       word;

    always_comb begin
        sync_hit    = sync_en && sync_pulse;
        restart     = !ctl_q.started || sync_hit;
        smp_en      = bit_valid && (!sync_en || ctl_q.cap);
        hold        = sync_en && sync_auto_stop && data_ready;
        push        = res_vld && !hold && !sync_hit;
        fifo_clr    = sync_hit && sync_fifo_clr;
        ctl_d         = ctl_q;
        ctl_d.started = 1'b1;
        if (sync_hit)  ctl_d.cap = 1'b1;
        else if (hold) ctl_d.cap = 1'b0;
        ctl_d.ovf = dropped;
        ctl_d.sat = push && clip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sinc_core #(.OSR_BITS(OSR_BITS), .ACC_W(ACC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .smp_en   (smp_en),
        .smp_bit  (bit_in),
        .order    (order_e'(cfg_order)),
        .ratio_m1 (cfg_ratio_m1),
        .res_vld  (res_vld),
        .res      (res)
    );

    pcm_format #(.IN_W(ACC_W), .OUT_W(DATA_W), .SH_W(SH_W)) u_fmt (
        .din   (res),
        .wide  (cfg_wide),
        .shift (cfg_shift),
        .word  (word),
        .clip  (clip)
    );

    pcm_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .push    (push),
        .din     (word),
        .pop     (pop),
        .dout    (rd_data),
        .count   (fifo_count),
        .dropped (dropped)
    );

    assign data_ready = (fifo_count >= cfg_thresh);
    assign overflow   = ctl_q.ovf;
    assign saturate   = ctl_q.sat;

endmodule

// File: rtl/sdm_capture_chk.sv
module sdm_capture_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_count,
    input logic          overflow,
    input logic          saturate,
    input logic          cfg_wide,
    input logic          pop,
    input logic          data_ready,
    input logic          sync_en,
    input logic          sync_pulse,
    input logic          sync_fifo_clr,
    input logic          sync_auto_stop
);
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R9
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(fifo_count) == CW'(DEPTH));

    // R6
    sat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        saturate |-> !$past(cfg_wide));

    // R11
    sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && sync_pulse && sync_fifo_clr) |=> fifo_count == '0);

    // R12
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && sync_auto_stop && data_ready && !sync_pulse && !pop)
        |=> $stable(fifo_count));

endmodule

bind sinc_capture_top sdm_capture_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_count     (fifo_count),
    .overflow       (overflow),
    .saturate       (saturate),
    .cfg_wide       (cfg_wide),
    .pop            (pop),
    .data_ready     (data_ready),
    .sync_en        (sync_en),
    .sync_pulse     (sync_pulse),
    .sync_fifo_clr  (sync_fifo_clr),
    .sync_auto_stop (sync_auto_stop)
);

// File: tb/tb_sinc_capture_top.sv
module tb_sinc_capture_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_valid, bit_in, cfg_wide, sync_en, sync_fifo_clr, sync_auto_stop, sync_pulse, pop;
    logic [1:0]  cfg_order;
    logic [7:0]  cfg_ratio_m1;
    logic [3:0]  cfg_shift;
    logic [4:0]  cfg_thresh;
    logic [31:0] rd_data;
    logic [4:0]  fifo_count;
    logic        data_ready, overflow, saturate;

    always #2.5 clk = ~clk;

    sinc_capture_top dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .cfg_order(cfg_order), .cfg_ratio_m1(cfg_ratio_m1), .cfg_wide(cfg_wide),
        .cfg_shift(cfg_shift), .cfg_thresh(cfg_thresh), .sync_en(sync_en),
        .sync_fifo_clr(sync_fifo_clr), .sync_auto_stop(sync_auto_stop),
        .sync_pulse(sync_pulse), .pop(pop), .rd_data(rd_data),
        .fifo_count(fifo_count), .data_ready(data_ready),
        .overflow(overflow), .saturate(saturate)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int ovf_seen = 0;
    int sat_seen = 0;
    int hist[0:4095];
    int hlen = 0;
    int wts[0:1023];
    int wlen = 1;
    bit rec = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) if (rst_n) begin
        if (overflow) ovf_seen++;
        if (saturate) sat_seen++;
    end

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int stages_of(int ord);
        return (ord == 0) ? 1 : (ord == 1) ? 2 : (ord == 2) ? 3 : 2;
    endfunction

    function automatic int settle_of(int ord);
        return (ord == 0) ? 0 : (ord == 1) ? 1 : 2;
    endfunction

    // N-fold boxcar of length R
    task automatic build_weights(int nst, int r);
        int tmp[0:1023];
        wlen = 1;
        wts[0] = 1;
        for (int s = 0; s < nst; s++) begin
            for (int i = 0; i < wlen + r - 1; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < r; j++)
                    if (i - j >= 0 && i - j < wlen) tmp[i] += wts[i - j];
            end
            wlen = wlen + r - 1;
            for (int i = 0; i < wlen; i++) wts[i] = tmp[i];
        end
    endtask

    function automatic longint model_out(int k, int r);
        longint acc = 0;
        int n = k * r - 1;
        for (int j = 0; j < wlen; j++)
            if (n - j >= 0) acc += longint'(wts[j]) * longint'(hist[n - j]);
        return acc;
    endfunction

    function automatic longint fmt16(longint v, int sh);
        longint s = v >>> sh;
        if (s > 32767)  return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic bit clips(longint v, int sh);
        longint s = v >>> sh;
        return (s > 32767) || (s < -32768);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; pop = 1'b0; sync_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        hlen = 0;
    endtask

    // mode 0: pseudo-random, 1: all ones, 2: all zeros
    task automatic feed(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bit_in = (mode == 0) ? lfsr[0] : (mode == 1);
            bit_valid = 1'b1;
            if (rec && hlen < 4096) begin
                hist[hlen] = bit_in ? 1 : -1;
                hlen++;
            end
        end
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_check(string req, longint exp);
        check(req, longint'($signed(rd_data)), exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic fire_sync();
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        hlen = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int rlist[4] = '{1, 3, 8, 20};
        int sat0;
        int ovf0;
        int exp_sat;
        longint e5, e6;
        cfg_order = 2'd0; cfg_ratio_m1 = 8'd0; cfg_wide = 1'b1; cfg_shift = 4'd0;
        cfg_thresh = 5'd1; sync_en = 1'b0; sync_fifo_clr = 1'b0; sync_auto_stop = 1'b0;
        do_reset();

        // R1 reset state
        check("R1 count", fifo_count, 0);
        check("R1 data_ready", data_ready, 0);
        check("R1 overflow", overflow, 0);
        check("R1 saturate", saturate, 0);

        // R2 R3 R4 R5: every order over several ratios, 32-bit words
        rec = 1'b1;
        cfg_thresh = 5'd16;
        for (int ord = 0; ord < 4; ord++) begin
            foreach (rlist[ri]) begin
                cfg_order = 2'(ord);
                cfg_ratio_m1 = 8'(rlist[ri] - 1);
                do_reset();
                build_weights(stages_of(ord), rlist[ri]);
                feed(rlist[ri] * (settle_of(ord) + 6), 0);
                check("R4 kept count", fifo_count, 6);
                for (int i = 0; i < 6; i++)
                    pop_check("R2 value", model_out(settle_of(ord) + 1 + i, rlist[ri]));
            end
        end

        // R3 R5 full scale at ratio 256, third order
        cfg_order = 2'd2; cfg_ratio_m1 = 8'd255;
        do_reset();
        feed(768, 1);
        check("R3 one output", fifo_count, 1);
        pop_check("R3 positive full scale", 256 * 256 * 256);
        do_reset();
        feed(768, 2);
        pop_check("R5 negative full scale", -(256 * 256 * 256));

        // R6 clamping boundaries, second order at 256: value +/-65536
        cfg_order = 2'd1; cfg_wide = 1'b0;
        cfg_shift = 4'd0; do_reset(); sat0 = sat_seen; feed(512, 1);
        pop_check("R6 clamp high", 32767);
        check("R6 sat pulse", sat_seen - sat0, 1);
        cfg_shift = 4'd1; do_reset(); sat0 = sat_seen; feed(512, 1);
        pop_check("R6 clamp 32768", 32767);
        check("R6 sat pulse", sat_seen - sat0, 1);
        cfg_shift = 4'd2; do_reset(); sat0 = sat_seen; feed(512, 1);
        pop_check("R6 no clamp", 16384);
        check("R6 no sat pulse", sat_seen - sat0, 0);
        cfg_shift = 4'd1; do_reset(); sat0 = sat_seen; feed(512, 2);
        pop_check("R6 exact low limit", -32768);
        check("R6 no sat pulse", sat_seen - sat0, 0);
        cfg_shift = 4'd0; do_reset(); sat0 = sat_seen; feed(512, 2);
        pop_check("R6 clamp low", -32768);
        check("R6 sat pulse", sat_seen - sat0, 1);

        // R6 random stream, third order ratio 40, shifts 0..3
        cfg_order = 2'd2; cfg_ratio_m1 = 8'd39;
        for (int sh = 0; sh < 4; sh++) begin
            cfg_shift = 4'(sh);
            do_reset();
            build_weights(3, 40);
            sat0 = sat_seen;
            feed(40 * 8, 0);
            exp_sat = 0;
            for (int i = 0; i < 6; i++) begin
                if (clips(model_out(3 + i, 40), sh)) exp_sat++;
                pop_check("R6 shifted value", fmt16(model_out(3 + i, 40), sh));
            end
            check("R6 sat count", sat_seen - sat0, exp_sat);
        end

        // R7 R8 R9 first order, ratio 1
        cfg_order = 2'd0; cfg_ratio_m1 = 8'd0; cfg_wide = 1'b1; cfg_thresh = 5'd5;
        do_reset();
        build_weights(1, 1);
        feed(4, 0);
        check("R8 below threshold", data_ready, 0);
        feed(1, 0);
        check("R8 at threshold", data_ready, 1);
        ovf0 = ovf_seen;
        feed(15, 0);
        check("R9 full", fifo_count, 16);
        check("R9 drop pulses", ovf_seen - ovf0, 4);
        for (int i = 0; i < 16; i++) pop_check("R7 order", model_out(1 + i, 1));
        check("R7 drained", fifo_count, 0);

        // R10 R11 R12 sync bursts, third order ratio 4, threshold 4
        cfg_order = 2'd2; cfg_ratio_m1 = 8'd3; cfg_thresh = 5'd4;
        sync_en = 1'b1; sync_fifo_clr = 1'b1; sync_auto_stop = 1'b1;
        rec = 1'b0;
        do_reset();
        build_weights(3, 4);
        feed(40, 0);
        check("R10 ignored before sync", fifo_count, 0);
        rec = 1'b1;
        fire_sync();
        feed(44, 0);
        check("R12 burst length", fifo_count, 4);
        check("R12 data_ready", data_ready, 1);
        feed(20, 0);
        check("R12 halted", fifo_count, 4);
        fire_sync();
        check("R11 cleared", fifo_count, 0);
        feed(44, 0);
        check("R10 restart burst", fifo_count, 4);
        pop_check("R10 value", model_out(3, 4));
        pop_check("R10 value", model_out(4, 4));
        e5 = model_out(5, 4);
        e6 = model_out(6, 4);
        sync_fifo_clr = 1'b0;
        fire_sync();
        check("R11 kept", fifo_count, 2);
        feed(44, 0);
        check("R12 topped up", fifo_count, 4);
        pop_check("R11 old first", e5);
        pop_check("R11 old second", e6);
        pop_check("R11 new first", model_out(3, 4));
        pop_check("R11 new second", model_out(4, 4));

        sync_fifo_clr = 1'b1; sync_auto_stop = 1'b0;
        fire_sync();
        ovf0 = ovf_seen;
        feed(4 * 20, 0);
        check("R12 continuous", fifo_count, 16);
        check("R12 continuous drops", ovf_seen - ovf0, 2);

        finish_run();
    end

endmodule